// File: doc/BRIEF.md
# Nested Priority Interrupt Entry Controller

This block decides when a processor core must take an interrupt and performs the hardware part of entering and leaving the handler. Requests arrive on a vector of level-sensitive lines, one line per priority level, plus an edge-triggered non-maskable line. The highest pending level is compared against the mask level held in the block's process-control word. When a request is taken, the block writes a four-word save frame to a stack memory port, moves the frame pointer and raises the mask. It also reports the vector number and marks the previous-frame return status as an interrupt return.

Handlers may nest: a request above the current mask interrupts a running handler. The frame pointer is loaded with the interrupt stack base only when the core is not already running on that stack. A return command reads the frame back, restores the process-control word and the arithmetic controls, and flags when the outermost handler has been left. The interrupted-state bit in the process-control word is the only record of nesting, so it drives both the stack switch and the outermost-exit report.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the process-control word equals PC_RESET, the frame pointer equals PROC_FP, the return-status field is 0, and there is no memory access and no busy indication.
- R2: Line k of irq_i requests level k; among active lines the highest k wins. Line 0 stands for level 0 and never causes an entry, so irq_i = 1 alone is ignored even at mask 0.
- R3: A maskable request is taken only when its level is strictly greater than the mask field (bits 20:16 of pc_o); mask 0 enables levels 1 to 31, and a level equal to or below the mask is ignored while held.
- R4: On entry the mask field becomes the taken level (31 for the non-maskable request), the interrupted bit (bit 13 of pc_o) becomes 1, the trace-enable bit (bit 0) becomes 0, vec_o becomes VEC_BASE + level and pfp_rs_o becomes 3'b111.
- R5: When bit 13 of pc_o is 0 at entry, the new frame pointer is ISTACK_BASE + 16; when it is 1, the new frame pointer is the current one + 16.
- R6: An entry issues exactly four consecutive word writes at new_fp-16 (saved pc_o), new_fp-12 (ac_i sampled at acceptance), new_fp-8 and new_fp-4 (both zero).
- R7: An entry keeps busy_o high for exactly five cycles (four writes, one frame-pointer update); request lines that change during those cycles do not affect the vector or the save frame.
- R8: A rising edge on nmi_i is taken even at mask 31 with vector NMI_VEC, wins over any maskable request, and a held-high nmi_i causes no further entry.
- R9: A return reads fp-16 then fp-12, and three cycles after ret_i it pulses ret_done_o with ac_restore_o holding the word read from fp-12; one cycle later pc_o holds the word read from fp-16 and the frame pointer has dropped by 16.
- R10: outermost_exit_o pulses together with ret_done_o exactly when bit 13 of the restored word is 0.
- R11: ret_i while bit 13 of pc_o is 0 is ignored: no memory access, no busy, pc_o and fp_o unchanged.
- R12: When ret_i and a request that would be taken arrive in the same idle cycle, the return runs first; the request is then judged against the restored mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LEVELS | Level request lines, line k is level k |
| nmi_i | input | 1 | Non-maskable request, rising edge |
| ret_i | input | 1 | Return-from-handler command |
| ac_i | input | XLEN | Current arithmetic controls of the core |
| mem_req_o | output | 1 | Stack memory access strobe |
| mem_we_o | output | 1 | Write enable of the access |
| mem_addr_o | output | XLEN | Byte address of the access |
| mem_wdata_o | output | XLEN | Write data |
| mem_rdata_i | input | XLEN | Read data, valid the cycle after a read |
| busy_o | output | 1 | Entry or return sequence running |
| entry_done_o | output | 1 | Last cycle of an entry sequence |
| vec_o | output | VEC_W | Vector number of the last taken request |
| pfp_rs_o | output | 3 | Return-status field for the previous frame |
| ret_done_o | output | 1 | Last cycle of a return sequence |
| outermost_exit_o | output | 1 | Return left the outermost handler |
| ac_restore_o | output | XLEN | Restored arithmetic controls, valid with ret_done_o |
| pc_o | output | XLEN | Process-control word |
| fp_o | output | XLEN | Frame pointer |

## Verification
The bench keeps the full 32 levels so that the top level 31 can meet a mask of 31 and the equal-level rule is exercised at both ends of the range. It moves ISTACK_BASE to 0x100 and PROC_FP to 0x800, which places every save frame of a three-deep nest, including one non-maskable entry, inside a 256-word memory model that answers reads one cycle late. The defaults of VEC_BASE and NMI_VEC make maskable and non-maskable vectors distinct, so a wrong winner shows up in vec_o.

// File: rtl/nie_pkg.sv
package nie_pkg;
  // process-control word fields
  localparam int unsigned PC_TRACE_BIT = 0;
  localparam int unsigned PC_STATE_BIT = 13;
  localparam int unsigned PC_PRIO_LSB  = 16;

  localparam int unsigned REC_WORDS = 4;
  localparam logic [2:0]  RS_INTR   = 3'b111;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_UPD,
    S_RD0,
    S_RD1,
    S_RD2
  } seq_state_e;
endpackage

// File: rtl/nie_prio_enc.sv
module nie_prio_enc #(
  parameter int unsigned NUM_LEVELS = 32,
  parameter int unsigned LVL_W      = $clog2(NUM_LEVELS)
) (
  input  logic [NUM_LEVELS-1:0] req_i,
  output logic                  valid_o,
  output logic [LVL_W-1:0]      lvl_o
);
  // ascending scan: the last hit is the highest level; level 0 maps to "none"
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (req_i[i]) lvl_o = LVL_W'(i);
    end
    valid_o = |lvl_o;
  end
endmodule

// File: rtl/nie_seq.sv
module nie_seq
  import nie_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned LVL_W       = 5,
  parameter int unsigned VEC_W       = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = VEC_W'('h20),
  parameter logic [VEC_W-1:0] NMI_VEC  = VEC_W'('hF8),
  parameter logic [XLEN-1:0]  ISTACK_BASE = XLEN'('h1000)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_valid_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic             nmi_pend_i,
  input  logic             ret_i,
  input  logic [LVL_W-1:0] mask_i,
  input  logic             intr_state_i,
  input  logic [XLEN-1:0]  fp_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  ac_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             nmi_ack_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  output logic             busy_o,
  output logic             entry_done_o,
  output logic             entry_nmi_o,
  output logic [LVL_W-1:0] new_lvl_o,
  output logic [XLEN-1:0]  new_fp_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             ret_done_o,
  output logic [XLEN-1:0]  rest_pc_o,
  output logic [XLEN-1:0]  rest_ac_o
);
  localparam int unsigned WORD_BYTES = XLEN / 8;
  localparam int unsigned WORD_SH    = $clog2(WORD_BYTES);
  localparam int unsigned BEAT_W     = $clog2(REC_WORDS);
  localparam logic [XLEN-1:0] WORD_X = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] REC_X  = XLEN'(REC_WORDS * WORD_BYTES);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(REC_WORDS - 1);

  seq_state_e        state_q;
  logic [BEAT_W-1:0] beat_q;
  logic [XLEN-1:0]   frame_q, sv_pc_q, sv_ac_q, rest_pc_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VEC_W-1:0]  vec_q;
  logic              nmi_q;

  logic idle, take_ret, take_nmi, take_irq;

  assign idle     = (state_q == S_IDLE);
  assign take_ret = idle && ret_i && intr_state_i;
  assign take_nmi = idle && !take_ret && nmi_pend_i;
  assign take_irq = idle && !take_ret && !nmi_pend_i && irq_valid_i && (irq_lvl_i > mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      beat_q    <= '0;
      frame_q   <= '0;
      sv_pc_q   <= '0;
      sv_ac_q   <= '0;
      rest_pc_q <= '0;
      lvl_q     <= '0;
      vec_q     <= '0;
      nmi_q     <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (take_ret) begin
            state_q <= S_RD0;
          end else if (take_nmi || take_irq) begin
            state_q <= S_WR;
            beat_q  <= '0;
            sv_pc_q <= pc_i;
            sv_ac_q <= ac_i;
            nmi_q   <= take_nmi;
            lvl_q   <= take_nmi ? '1 : irq_lvl_i;
            vec_q   <= take_nmi ? NMI_VEC : VEC_BASE + VEC_W'(irq_lvl_i);
            frame_q <= (intr_state_i ? fp_i : ISTACK_BASE) + REC_X;
          end
        end
        S_WR: begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state_q <= S_UPD;
        end
        S_UPD: state_q <= S_IDLE;
        S_RD0: state_q <= S_RD1;
        S_RD1: begin
          rest_pc_q <= mem_rdata_i;
          state_q   <= S_RD2;
        end
        S_RD2:   state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      S_WR: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = frame_q - REC_X + (XLEN'(beat_q) << WORD_SH);
        if (beat_q == BEAT_W'(0))      mem_wdata_o = sv_pc_q;
        else if (beat_q == BEAT_W'(1)) mem_wdata_o = sv_ac_q;
      end
      S_RD0: begin
        mem_req_o  = 1'b1;
        mem_addr_o = fp_i - REC_X;
      end
      S_RD1: begin
        mem_req_o  = 1'b1;
        mem_addr_o = fp_i - REC_X + WORD_X;
      end
      default: ;
    endcase
  end

  assign nmi_ack_o    = take_nmi;
  assign busy_o       = !idle;
  assign entry_done_o = (state_q == S_UPD);
  assign entry_nmi_o  = nmi_q;
  assign new_lvl_o    = lvl_q;
  assign new_fp_o     = frame_q;
  assign vec_o        = vec_q;
  assign ret_done_o   = (state_q == S_RD2);
  assign rest_pc_o    = rest_pc_q;
  assign rest_ac_o    = mem_rdata_i;

  // checker: cycles spent writing before the update cycle
  logic [BEAT_W:0] wr_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               wr_cnt_q <= '0;
    else if (state_q == S_WR)  wr_cnt_q <= wr_cnt_q + 1'b1;
    else                       wr_cnt_q <= '0;
  end

  assert_entry_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_done_o |-> (wr_cnt_q == (BEAT_W+1)'(REC_WORDS)));

  assert_rec_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && beat_q != LAST_BEAT)
      |=> (mem_req_o && mem_we_o && mem_addr_o == $past(mem_addr_o) + WORD_X));

  assert_ret_reads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_done_o |-> (!mem_req_o && $past(mem_req_o) && !$past(mem_we_o)));
endmodule

// File: rtl/nie_state_regs.sv
module nie_state_regs
  import nie_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned LVL_W = 5,
  parameter logic [XLEN-1:0] PC_RESET = XLEN'(1),
  parameter logic [XLEN-1:0] PROC_FP  = XLEN'('h400)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             nmi_ack_i,
  input  logic             entry_done_i,
  input  logic [LVL_W-1:0] new_lvl_i,
  input  logic [XLEN-1:0]  new_fp_i,
  input  logic             ret_done_i,
  input  logic [XLEN-1:0]  rest_pc_i,
  output logic             nmi_pend_o,
  output logic [LVL_W-1:0] mask_o,
  output logic             intr_state_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  fp_o,
  output logic [2:0]       pfp_rs_o,
  output logic             outermost_exit_o
);
  localparam logic [XLEN-1:0] REC_X = XLEN'(REC_WORDS * (XLEN / 8));

  logic [XLEN-1:0] pc_q, fp_q, pc_entered;
  logic [2:0]      rs_q;
  logic            nmi_d_q, nmi_pend_q;

  always_comb begin
    pc_entered = pc_q;
    pc_entered[PC_PRIO_LSB +: LVL_W] = new_lvl_i;
    pc_entered[PC_STATE_BIT]         = 1'b1;
    pc_entered[PC_TRACE_BIT]         = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= PC_RESET;
      fp_q       <= PROC_FP;
      rs_q       <= '0;
      nmi_d_q    <= 1'b0;
      nmi_pend_q <= 1'b0;
    end else begin
      nmi_d_q <= nmi_i;
      if (nmi_i && !nmi_d_q) nmi_pend_q <= 1'b1;
      else if (nmi_ack_i)    nmi_pend_q <= 1'b0;
      if (entry_done_i) begin
        pc_q <= pc_entered;
        fp_q <= new_fp_i;
        rs_q <= RS_INTR;
      end else if (ret_done_i) begin
        pc_q <= rest_pc_i;
        fp_q <= fp_q - REC_X;
      end
    end
  end

  assign nmi_pend_o       = nmi_pend_q;
  assign mask_o           = pc_q[PC_PRIO_LSB +: LVL_W];
  assign intr_state_o     = pc_q[PC_STATE_BIT];
  assign pc_o             = pc_q;
  assign fp_o             = fp_q;
  assign pfp_rs_o         = rs_q;
  assign outermost_exit_o = ret_done_i && !rest_pc_i[PC_STATE_BIT];

  assert_fp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(entry_done_i || ret_done_i) |=> $stable(fp_q));

  assert_nmi_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_q && !nmi_ack_i) |=> nmi_pend_q);

  assert_exit_nested_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outermost_exit_o |-> intr_state_o);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nie_pkg::*;
#(
  parameter int unsigned NUM_LEVELS = 32,
  parameter int unsigned XLEN       = 32,
  parameter int unsigned VEC_W      = 8,
  parameter logic [VEC_W-1:0] VEC_BASE    = VEC_W'('h20),
  parameter logic [VEC_W-1:0] NMI_VEC     = VEC_W'('hF8),
  parameter logic [XLEN-1:0]  ISTACK_BASE = XLEN'('h1000),
  parameter logic [XLEN-1:0]  PROC_FP     = XLEN'('h400),
  parameter logic [XLEN-1:0]  PC_RESET    = XLEN'(1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LEVELS-1:0] irq_i,
  input  logic                  nmi_i,
  input  logic                  ret_i,
  input  logic [XLEN-1:0]       ac_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [XLEN-1:0]       mem_addr_o,
  output logic [XLEN-1:0]       mem_wdata_o,
  input  logic [XLEN-1:0]       mem_rdata_i,
  output logic                  busy_o,
  output logic                  entry_done_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [2:0]            pfp_rs_o,
  output logic                  ret_done_o,
  output logic                  outermost_exit_o,
  output logic [XLEN-1:0]       ac_restore_o,
  output logic [XLEN-1:0]       pc_o,
  output logic [XLEN-1:0]       fp_o
);
  localparam int unsigned LVL_W = $clog2(NUM_LEVELS);

  logic             irq_valid, nmi_pend, nmi_ack, intr_state, entry_nmi;
  logic [LVL_W-1:0] irq_lvl, mask, new_lvl;
  logic [XLEN-1:0]  new_fp, rest_pc;

  nie_prio_enc #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W)
  ) u_prio (
    .req_i   (irq_i),
    .valid_o (irq_valid),
    .lvl_o   (irq_lvl)
  );

  nie_seq #(
    .XLEN        (XLEN),
    .LVL_W       (LVL_W),
    .VEC_W       (VEC_W),
    .VEC_BASE    (VEC_BASE),
    .NMI_VEC     (NMI_VEC),
    .ISTACK_BASE (ISTACK_BASE)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_valid_i  (irq_valid),
    .irq_lvl_i    (irq_lvl),
    .nmi_pend_i   (nmi_pend),
    .ret_i        (ret_i),
    .mask_i       (mask),
    .intr_state_i (intr_state),
    .fp_i         (fp_o),
    .pc_i         (pc_o),
    .ac_i         (ac_i),
    .mem_rdata_i  (mem_rdata_i),
    .nmi_ack_o    (nmi_ack),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .busy_o       (busy_o),
    .entry_done_o (entry_done_o),
    .entry_nmi_o  (entry_nmi),
    .new_lvl_o    (new_lvl),
    .new_fp_o     (new_fp),
    .vec_o        (vec_o),
    .ret_done_o   (ret_done_o),
    .rest_pc_o    (rest_pc),
    .rest_ac_o    (ac_restore_o)
  );

  nie_state_regs #(
    .XLEN     (XLEN),
    .LVL_W    (LVL_W),
    .PC_RESET (PC_RESET),
    .PROC_FP  (PROC_FP)
  ) u_regs (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .nmi_i            (nmi_i),
    .nmi_ack_i        (nmi_ack),
    .entry_done_i     (entry_done_o),
    .new_lvl_i        (new_lvl),
    .new_fp_i         (new_fp),
    .ret_done_i       (ret_done_o),
    .rest_pc_i        (rest_pc),
    .nmi_pend_o       (nmi_pend),
    .mask_o           (mask),
    .intr_state_o     (intr_state),
    .pc_o             (pc_o),
    .fp_o             (fp_o),
    .pfp_rs_o         (pfp_rs_o),
    .outermost_exit_o (outermost_exit_o)
  );

  assert_mask_raise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_done_o && !entry_nmi) |-> (new_lvl > mask));

  assert_mask_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_done_o |=> (mask == $past(new_lvl) && intr_state && !pc_o[PC_TRACE_BIT]));
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  localparam logic [31:0] IBASE = 32'h100;
  localparam logic [31:0] PFP   = 32'h800;
  localparam logic [31:0] PCR   = 32'h1;
  localparam logic [7:0]  VB    = 8'h20;
  localparam logic [7:0]  NV    = 8'hF8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq = '0;
  logic        nmi = 1'b0, ret = 1'b0;
  logic [31:0] ac = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, entry_done, ret_done, oexit;
  logic [7:0]  vec;
  logic [2:0]  pfp_rs;
  logic [31:0] ac_rest, pc, fp;

  always #10ns clk = ~clk;

  nest_irq_ctrl #(
    .NUM_LEVELS (32), .XLEN (32), .VEC_W (8), .VEC_BASE (VB), .NMI_VEC (NV),
    .ISTACK_BASE (IBASE), .PROC_FP (PFP), .PC_RESET (PCR)
  ) dut (
    .clk_i (clk), .rst_ni (rst_n), .irq_i (irq), .nmi_i (nmi), .ret_i (ret), .ac_i (ac),
    .mem_req_o (mem_req), .mem_we_o (mem_we), .mem_addr_o (mem_addr),
    .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata), .busy_o (busy),
    .entry_done_o (entry_done), .vec_o (vec), .pfp_rs_o (pfp_rs),
    .ret_done_o (ret_done), .outermost_exit_o (oexit), .ac_restore_o (ac_rest),
    .pc_o (pc), .fp_o (fp)
  );

  logic [31:0] mem [0:255];
  logic [31:0] wa [0:63];
  logic [31:0] wd [0:63];
  int wcnt = 0;
  initial mem_rdata = '0;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] <= mem_wdata;
        wa[wcnt % 64]      <= mem_addr;
        wd[wcnt % 64]      <= mem_wdata;
        wcnt               <= wcnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[9:2]];
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req, input int n);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || mem_req || ret_done) bad++;
    end
    chk(req, "active cycles while request must be ignored", bad, 0);
  endtask

  task automatic run_entry(input string req, input logic [7:0] exp_vec,
                           input logic [31:0] exp_fp, input logic [31:0] exp_spc,
                           input logic [31:0] exp_ac, input logic [31:0] exp_pc,
                           input int glitch);
    int base, nb;
    base = wcnt;
    nb   = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) begin
        nb++;
        if (glitch > 0 && nb == 2) irq[glitch] = 1'b1;
        if (glitch > 0 && nb == 3) irq[glitch] = 1'b0;
      end else if (nb > 0) begin
        break;
      end
    end
    chk("R7", {req, " busy cycles"}, nb, 5);
    chk("R4", {req, " vector"}, {24'h0, vec}, {24'h0, exp_vec});
    chk("R4", {req, " pc after entry"}, pc, exp_pc);
    chk("R4", {req, " return status"}, {29'h0, pfp_rs}, 32'h7);
    chk("R5", {req, " frame pointer"}, fp, exp_fp);
    chk("R6", {req, " write count"}, wcnt - base, 4);
    chk("R6", {req, " addr saved pc"}, wa[base % 64], exp_fp - 16);
    chk("R6", {req, " saved pc"}, wd[base % 64], exp_spc);
    chk("R6", {req, " addr saved ac"}, wa[(base + 1) % 64], exp_fp - 12);
    chk("R6", {req, " saved ac"}, wd[(base + 1) % 64], exp_ac);
    chk("R6", {req, " addr pad words"}, wa[(base + 3) % 64] - wa[(base + 2) % 64], 4);
    chk("R6", {req, " pad words zero"}, wd[(base + 2) % 64] | wd[(base + 3) % 64], 0);
  endtask

  task automatic run_ret(input string req, input logic [31:0] exp_pc,
                         input logic [31:0] exp_fp, input logic [31:0] exp_ac,
                         input logic exp_exit);
    int wait_n;
    logic got_exit;
    logic [31:0] got_ac;
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    chk(req, "first access is a read (R9)", {30'h0, mem_req, mem_we}, 32'h2);
    chk(req, "read address fp-16 (R9)", mem_addr, exp_fp);
    wait_n   = 0;
    got_exit = 1'bx;
    got_ac   = 'x;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wait_n++;
      if (ret_done) begin
        got_exit = oexit;
        got_ac   = ac_rest;
        break;
      end
    end
    chk(req, "cycles to ret_done (R9)", wait_n, 2);
    chk(req, "restored ac (R9)", got_ac, exp_ac);
    chk(req, "outermost exit flag (R10)", {31'h0, got_exit}, {31'h0, exp_exit});
    @(negedge clk);
    chk(req, "restored pc (R9)", pc, exp_pc);
    chk(req, "fp after return (R9)", fp, exp_fp);
  endtask

  initial begin
    #3ms;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc reset", pc, PCR);
    chk("R1", "fp reset", fp, PFP);
    chk("R1", "rs reset", {29'h0, pfp_rs}, 0);
    chk("R1", "idle", {30'h0, busy, mem_req}, 0);

    // R2 highest of 3,5,9 wins; outermost load of stack base
    irq = 32'h0000_0229;
    ac  = 32'hA5A5_0001;
    run_entry("R2 outermost", VB + 8'd9, IBASE + 16, PCR, 32'hA5A5_0001, 32'h0009_2000, 0);
    // R3 equal and lower levels ignored
    quiet("R3 held 9/5/3 at mask 9", 8);

    // nested entry; level 20 toggles mid-sequence and must not matter (R7)
    irq[12] = 1'b1;
    ac = 32'hA5A5_0002;
    run_entry("R5 nested", VB + 8'd12, IBASE + 32, 32'h0009_2000, 32'hA5A5_0002,
              32'h000C_2000, 20);

    // R8 non-maskable edge
    nmi = 1'b1;
    ac  = 32'hA5A5_0003;
    run_entry("R8 nmi", NV, IBASE + 48, 32'h000C_2000, 32'hA5A5_0003, 32'h001F_2000, 0);
    irq[31] = 1'b1;
    quiet("R3 R8 level 31 at mask 31, nmi held", 8);
    irq = '0;
    nmi = 1'b0;

    run_ret("R9 nested", 32'h000C_2000, IBASE + 32, 32'hA5A5_0003, 1'b0);

    // R12 return and pending request together
    irq[15] = 1'b1;
    ac = 32'hA5A5_0004;
    run_ret("R12", 32'h0009_2000, IBASE + 16, 32'hA5A5_0002, 1'b0);
    run_entry("R12 deferred", VB + 8'd15, IBASE + 32, 32'h0009_2000, 32'hA5A5_0004,
              32'h000F_2000, 0);
    irq = '0;
    run_ret("R9 again", 32'h0009_2000, IBASE + 16, 32'hA5A5_0004, 1'b0);
    run_ret("R10 outermost", PCR, IBASE, 32'hA5A5_0001, 1'b1);

    // R11 return while not interrupted
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    chk("R11", "no access on ignored return", {31'h0, mem_req | busy}, 0);
    quiet("R11 ignored return", 6);
    chk("R11", "fp unchanged", fp, IBASE);
    chk("R11", "pc unchanged", pc, PCR);

    // R2 line 0 alone ignored, line 1 taken at mask 0
    irq = 32'h1;
    quiet("R2 level 0 line", 6);
    irq = 32'h2;
    ac  = 32'hA5A5_0005;
    run_entry("R3 mask zero", VB + 8'd1, IBASE + 16, PCR, 32'hA5A5_0005, 32'h0001_2000, 0);
    irq = '0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule